// File: doc/BRIEF.md
# Lockable Copy-Back Data Cache

A small set-associative data cache that sits between a CPU-side load/store port and a word-wide memory port. Each line holds one 32-bit word. When a store hits, only the cached copy is updated and the line is marked dirty. Memory sees that value only when the line is later evicted.

Besides load and store, the CPU port accepts three maintenance commands that carry an address:

- **lock** allocates the line, fetching it if needed, and pins it.
- **unlock** removes the pin.
- **invalidate** drops the line and discards any dirty data.

Pinned lines are never chosen as victims. When every way of a set is pinned, the set stops allocating. Stores to that set go straight to memory, and loads read memory without filling the cache.

The CPU side handles one operation at a time. An operation is accepted while the block is idle, and a one-cycle done pulse marks its completion. The memory side uses a valid/ready handshake with a write-enable.

Top module: `lcb_dcache`

## Requirements
- R1: After reset no line is valid, and `busy_o`, `done_o` and `mem_req_o` are low.
- R2: A load hit returns the cached word, and a store hit updates only the cached word and marks it dirty. Neither makes a memory transfer.
- R3: A load or store miss to a set that is not fully locked allocates a way. A load miss fetches the word from memory and returns it. A store miss installs the store data as a dirty line without fetching.
- R4: A victim line that is valid and dirty is written to its own address in memory before the new line is installed. A clean victim makes no write.
- R5: The victim is the lowest-numbered invalid way if there is one. Otherwise it is the first unlocked way found scanning upward from the set's round-robin pointer. After each allocation that pointer moves to the way after the victim.
- R6: A lock command (op 2) that hits sets the line's lock bit. On a miss it allocates the line, fetches it and locks it. A locked line is never replaced.
- R7: When all four ways of the target set are valid and locked:
  - a store miss writes its data straight to memory with one transfer and allocates nothing;
  - a load miss returns the memory word with one read and does not fill;
  - a lock miss completes with no memory transfer.
- R8: An invalidate command (op 4) that hits clears the line's valid, lock and dirty state with no write-back, so later reads return memory. On a miss it completes with no memory transfer.
- R9: An unlock command (op 3) that hits clears only the lock bit, keeping the data and dirty state. On a miss it completes with no memory transfer.
- R10: While `mem_req_o` is high and `mem_ready_i` is low, `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold their values.
- R11: CPU protocol:
  - `op_i` encodes load=0, store=1, lock=2, unlock=3, invalidate=4.
  - A request is taken when `req_i` is high and `busy_o` is low.
  - `busy_o` rises on the next cycle.
  - `done_o` pulses for exactly one cycle, in the cycle `busy_o` falls.
- R12: With the default parameters, address bits [3:2] select one of four sets and bits [31:4] form the tag, so addresses 0x1000 apart share one set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | CPU request strobe |
| op_i | input | 3 | Operation code |
| addr_i | input | 32 | Byte address, word aligned |
| wdata_i | input | 32 | Store data |
| rdata_o | output | 32 | Load result, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts / completes the transfer |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |

## Verification
The bench builds the block with its defaults: four ways, four sets, and the set index at bit 2. With those values a 0x1000 stride lands in a single set, so four lock commands fully pin a set. A fifth address in that set then exercises the bypass paths.

The same small geometry means that six stores to one unlocked set wrap the round-robin pointer. Those stores force dirty write-backs in a known order, which the bench's behavioural model predicts. The model is compared against the memory image, the read data and the transfer count of every operation.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_LOCK   = 3'd2,
    OP_UNLOCK = 3'd3,
    OP_INVAL  = 3'd4
  } lcb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FILL,
    ST_BYP_RD,
    ST_BYP_WR
  } lcb_state_e;
endpackage

// File: rtl/lcb_tag_match.sv
module lcb_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 28,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (eq[i]) way_o = WAY_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/lcb_victim_sel.sv
module lcb_victim_sel #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  lock_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             full_lock_o
);
  logic found;

  assign full_lock_o = &(valid_i & lock_i);

  always_comb begin
    way_o = '0;
    found = 1'b0;
    // invalid ways first, lowest index wins
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !valid_i[i]) begin
        way_o = WAY_W'(i);
        found = 1'b1;
      end
    end
    // then round-robin over unlocked ways
    for (int k = 0; k < WAYS; k++) begin
      if (!found && !lock_i[WAY_W'(rr_i + WAY_W'(k))]) begin
        way_o = WAY_W'(rr_i + WAY_W'(k));
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcb_dcache.sv
module lcb_dcache
  import lcb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WAYS    = 4,
  parameter int SETS    = 4,
  parameter int IDX_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_LSB - SET_W;

  logic [SETS-1:0][WAYS-1:0]             vld_q, lck_q, drt_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] dat_q;
  logic [SETS-1:0][WAY_W-1:0]            rr_q;

  lcb_state_e        state_q;
  lcb_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [WAY_W-1:0]  vic_q;
  logic              done_q;

  logic [SET_W-1:0]  set_w;
  logic [TAG_W-1:0]  ctag_w;
  logic              hit_w, full_w;
  logic [WAY_W-1:0]  hway_w, vic_w;

  assign set_w  = addr_q[IDX_LSB +: SET_W];
  assign ctag_w = addr_q[ADDR_W-1 -: TAG_W];

  lcb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i (vld_q[set_w]),
    .tags_i  (tag_q[set_w]),
    .tag_i   (ctag_w),
    .hit_o   (hit_w),
    .way_o   (hway_w)
  );

  lcb_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid_i     (vld_q[set_w]),
    .lock_i      (lck_q[set_w]),
    .rr_i        (rr_q[set_w]),
    .way_o       (vic_w),
    .full_lock_o (full_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      vic_q   <= '0;
      done_q  <= 1'b0;
      vld_q   <= '0;
      lck_q   <= '0;
      drt_q   <= '0;
      tag_q   <= '0;
      dat_q   <= '0;
      rr_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            op_q    <= lcb_op_e'(op_i);
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            state_q <= ST_LOOK;
          end
        end

        ST_LOOK: begin
          if (hit_w) begin
            unique case (op_q)
              OP_LOAD:   rdata_q <= dat_q[set_w][hway_w];
              OP_STORE: begin
                dat_q[set_w][hway_w] <= wdata_q;
                drt_q[set_w][hway_w] <= 1'b1;
              end
              OP_LOCK:   lck_q[set_w][hway_w] <= 1'b1;
              OP_UNLOCK: lck_q[set_w][hway_w] <= 1'b0;
              default: begin
                vld_q[set_w][hway_w] <= 1'b0;
                lck_q[set_w][hway_w] <= 1'b0;
                drt_q[set_w][hway_w] <= 1'b0;
              end
            endcase
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (op_q == OP_UNLOCK || op_q == OP_INVAL ||
                       (op_q == OP_LOCK && full_w)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (full_w) begin
            state_q <= (op_q == OP_STORE) ? ST_BYP_WR : ST_BYP_RD;
          end else begin
            vic_q         <= vic_w;
            rr_q[set_w]   <= WAY_W'(vic_w + 1'b1);
            if (vld_q[set_w][vic_w] && drt_q[set_w][vic_w]) begin
              state_q <= ST_WBACK;
            end else if (op_q == OP_STORE) begin
              vld_q[set_w][vic_w] <= 1'b1;
              lck_q[set_w][vic_w] <= 1'b0;
              drt_q[set_w][vic_w] <= 1'b1;
              tag_q[set_w][vic_w] <= ctag_w;
              dat_q[set_w][vic_w] <= wdata_q;
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end

        ST_WBACK: begin
          if (mem_ready_i) begin
            drt_q[set_w][vic_q] <= 1'b0;
            if (op_q == OP_STORE) begin
              vld_q[set_w][vic_q] <= 1'b1;
              lck_q[set_w][vic_q] <= 1'b0;
              drt_q[set_w][vic_q] <= 1'b1;
              tag_q[set_w][vic_q] <= ctag_w;
              dat_q[set_w][vic_q] <= wdata_q;
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end

        ST_FILL: begin
          if (mem_ready_i) begin
            vld_q[set_w][vic_q] <= 1'b1;
            lck_q[set_w][vic_q] <= (op_q == OP_LOCK);
            drt_q[set_w][vic_q] <= 1'b0;
            tag_q[set_w][vic_q] <= ctag_w;
            dat_q[set_w][vic_q] <= mem_rdata_i;
            if (op_q == OP_LOAD) rdata_q <= mem_rdata_i;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end

        ST_BYP_RD: begin
          if (mem_ready_i) begin
            rdata_q <= mem_rdata_i;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end

        ST_BYP_WR: begin
          if (mem_ready_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {addr_q[ADDR_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
    mem_wdata_o = wdata_q;
    unique case (state_q)
      ST_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {tag_q[set_w][vic_q], set_w, {IDX_LSB{1'b0}}};
        mem_wdata_o = dat_q[set_w][vic_q];
      end
      ST_FILL, ST_BYP_RD: mem_req_o = 1'b1;
      ST_BYP_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign rdata_o = rdata_q;
  assign done_o  = done_q;
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/lcb_dcache_chk.sv
module lcb_dcache_chk
  import lcb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_LSB = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [2:0]        op_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              done_o,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i
);
  logic [2:0]        op_t;
  logic [ADDR_W-1:0] addr_t;
  logic [DATA_W-1:0] wdata_t;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_t    <= '0;
      addr_t  <= '0;
      wdata_t <= '0;
    end else if (req_i && !busy_o) begin
      op_t    <= op_i;
      addr_t  <= {addr_i[ADDR_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
      wdata_t <= wdata_i;
    end
  end

  // R11
  req_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));

  // R8 R9
  maint_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (op_t == 3'(OP_UNLOCK) || op_t == 3'(OP_INVAL)) |-> !mem_req_o);

  // R7
  byp_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && op_t == 3'(OP_STORE) && mem_req_o && mem_we_o && mem_addr_o == addr_t
      |-> mem_wdata_o == wdata_t);

  // R4
  load_no_self_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && op_t == 3'(OP_LOAD) && mem_req_o && mem_we_o |-> mem_addr_o != addr_t);
endmodule

bind lcb_dcache lcb_dcache_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IDX_LSB(IDX_LSB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .op_i        (op_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .done_o      (done_o),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/tb_lcb_dcache.sv
module tb_lcb_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        done, busy;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int total = 0, bad = 0, xfers = 0, lat = 1;
  bit finished = 0;

  logic [31:0] mem[logic [31:0]];
  logic [31:0] exp_mem[logic [31:0]];

  bit          m_vld[4][4], m_lck[4][4], m_drt[4][4];
  logic [31:0] m_tag[4][4], m_dat[4][4];
  int          m_rr[4];

  always #5 clk = ~clk;

  lcb_dcache dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] rd_exp(logic [31:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] rd_mem(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory responder: one cycle latency, one transfer per ready pulse
  initial forever begin
    @(negedge clk);
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req) begin
      if (lat > 0) lat--;
      else begin
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd_mem(mem_addr);
        xfers++;
        mem_ready = 1'b1;
        lat = 1;
      end
    end
  end

  // behavioural model of one operation
  task automatic model(input int o, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] erd, output int exf);
    int s = int'(a[3:2]);
    logic [31:0] t = a >> 4;
    int hw = -1, v = -1;
    bit full = 1;
    erd = 'x;
    exf = 0;
    for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t && hw < 0) hw = w;
    for (int w = 0; w < 4; w++) if (!(m_vld[s][w] && m_lck[s][w])) full = 0;
    if (hw >= 0) begin
      case (o)
        0: erd = m_dat[s][hw];
        1: begin m_dat[s][hw] = wd; m_drt[s][hw] = 1; end
        2: m_lck[s][hw] = 1;
        3: m_lck[s][hw] = 0;
        default: begin m_vld[s][hw] = 0; m_lck[s][hw] = 0; m_drt[s][hw] = 0; end
      endcase
      return;
    end
    if (o >= 3 || (o == 2 && full)) return;
    if (full) begin
      exf = 1;
      if (o == 1) exp_mem[a] = wd;
      else erd = rd_exp(a);
      return;
    end
    for (int w = 0; w < 4; w++) if (!m_vld[s][w] && v < 0) v = w;
    for (int k = 0; k < 4; k++) if (v < 0 && !m_lck[s][(m_rr[s] + k) % 4]) v = (m_rr[s] + k) % 4;
    m_rr[s] = (v + 1) % 4;
    if (m_vld[s][v] && m_drt[s][v]) begin
      exp_mem[(m_tag[s][v] << 4) | (32'(s) << 2)] = m_dat[s][v];
      exf++;
    end
    m_vld[s][v] = 1;
    m_tag[s][v] = t;
    if (o == 1) begin
      m_dat[s][v] = wd; m_drt[s][v] = 1; m_lck[s][v] = 0;
    end else begin
      exf++;
      m_dat[s][v] = rd_exp(a); m_drt[s][v] = 0; m_lck[s][v] = (o == 2);
      erd = m_dat[s][v];
    end
  endtask

  task automatic run(string r, int o, logic [31:0] a, logic [31:0] wd = 0);
    logic [31:0] erd;
    int exf, x0, n;
    model(o, a, wd, erd, exf);
    x0 = xfers;
    @(negedge clk);
    req = 1'b1; op = 3'(o); addr = a; wdata = wd;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (!done && n < 50) begin
      // per-clock: no memory traffic when the model predicts none
      if (exf == 0) chk({r, " quiet"}, 32'(mem_req), 32'h0);
      @(negedge clk);
      n++;
    end
    chk({r, " done"}, 32'(done), 32'h1);
    chk({r, " busy low at done"}, 32'(busy), 32'h0);
    if (o == 0) chk({r, " rdata"}, rdata, erd);
    chk({r, " transfers"}, 32'(xfers - x0), 32'(exf));
    foreach (exp_mem[k]) chk({r, " mem image"}, rd_mem(k), exp_mem[k]);
    foreach (mem[k]) chk({r, " mem extra"}, mem[k], rd_exp(k));
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_sim();
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 0; m_lck[s][w] = 0; m_drt[s][w] = 0;
        m_tag[s][w] = 0; m_dat[s][w] = 0;
      end
    end
    mem[32'h76000] = 32'h5a5a_0001; exp_mem[32'h76000] = 32'h5a5a_0001;
    mem[32'h90008] = 32'h0bad_cafe; exp_mem[32'h90008] = 32'h0bad_cafe;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    run("R1 load after reset misses", 0, 32'h90008);

    // R6 R12: lock four lines 0x1000 apart, then fill them with stores that hit
    run("R6 lock miss", 2, 32'h70000);
    run("R6 lock miss", 2, 32'h71000);
    run("R6 lock miss", 2, 32'h72000);
    run("R12 lock fills set", 2, 32'h73000);
    run("R2 store hit", 1, 32'h70000, 32'h1111_1111);
    run("R2 store hit", 1, 32'h71000, 32'h2222_2222);
    run("R2 store hit", 1, 32'h72000, 32'h3333_3333);
    run("R2 store hit", 1, 32'h73000, 32'h4444_4444);
    run("R2 load hit", 0, 32'h72000);
    // R7: fully locked set
    run("R7 store bypass", 1, 32'h74000, 32'hdead_beef);
    run("R7 load bypass", 0, 32'h76000);
    run("R7 load bypass no fill", 0, 32'h76000);
    run("R7 lock no-op", 2, 32'h77000);
    // R8: invalidate drops dirty data
    run("R8 inval hit", 4, 32'h70000);
    run("R8 inval hit", 4, 32'h71000);
    run("R8 inval miss", 4, 32'h74000);
    run("R8 read memory after inval", 0, 32'h70000);
    run("R3 load miss fetches", 0, 32'h74000);
    // R9: unlock keeps dirty data, line becomes replaceable
    run("R9 unlock miss", 3, 32'h7f000);
    run("R6 relock hit", 2, 32'h70000);
    run("R6 relock miss", 2, 32'h71000);
    run("R2 store hit", 1, 32'h70000, 32'h1111_1111);
    run("R2 store hit", 1, 32'h71000, 32'h2222_2222);
    run("R9 unlock hit", 3, 32'h72000);
    run("R9 unlocked data kept", 0, 32'h72000);
    run("R4 store miss evicts unlocked dirty", 1, 32'h75000, 32'hbeef_dead);
    run("R6 locked line kept", 0, 32'h71000);
    run("R4 old value readable", 0, 32'h72000);
    run("R3 store miss no fetch", 1, 32'h78000, 32'h0000_7777);
    // R5: round-robin in an unlocked set
    for (int k = 0; k < 6; k++) run("R5 store sweep", 1, 32'h80004 + 32'(k) * 32'h1000, 32'hc000_0000 + 32'(k));
    run("R5 lock in sweep set", 2, 32'h83004);
    for (int k = 6; k < 9; k++) run("R5 store skip locked", 1, 32'h80004 + 32'(k) * 32'h1000, 32'hc000_0000 + 32'(k));
    for (int k = 0; k < 9; k++) run("R3 load back", 0, 32'h80004 + 32'(k) * 32'h1000);
    run("R11 back-to-back", 0, 32'h83004);
    finish_sim();
  end
endmodule